// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-up to the idle state. After reset it checks the configuration inputs: burst length, burst type and CAS latency. Once they are legal it copies them into a register and starts a fixed bring-up.

The bring-up runs in this order:
- a long hold of NOP commands, with the length set from the clock period;
- one precharge of all banks;
- a load of the extended mode register that enables the DLL;
- a load of the mode register that also resets the DLL;
- a programmable number of auto refreshes;
- a hold of 200 cycles.

At the end it raises a done flag and drives NOP from then on.

The command pins, bank address and 13-bit address bus are the block's only view of the memory. The integrating controller hands these pins over to normal traffic once done is high. If a configuration is illegal, the block raises an error flag and waits before doing anything. It starts as soon as the inputs become legal, and no reset is needed for that.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next cycle shows a NOP, `init_done` low and the sequence back at its start. After release, the whole bring-up runs again, including the full power-up hold.
- R2: At least `ceil(POWERUP_NS*1000/CLK_PERIOD_PS)` cycles of NOP pass after reset release before the first non-NOP command.
- R3: The non-NOP commands appear in exactly this order: one precharge, one extended mode load, one mode load, then the refreshes. No further command follows.
- R4: The number of auto refreshes equals `REFRESH_COUNT`. A value below 2 is raised to 2.
- R5: `init_done` is first seen exactly 201 cycles after the last refresh, which leaves 200 NOP cycles in between. It then stays high and the command stays NOP.
- R6: The mode load word carries the following fields:
  - A2..A0 holds burst length: 2→001, 4→010, 8→011.
  - A3 holds burst type: 1 means interleaved.
  - A6..A4 holds CAS latency: input 4 half-cycles→010, 5→110.
  - A8 is 1, which resets the DLL.
  - A7 and A12..A9 are 0.
- R7: The mode load uses BA=00. The extended mode load uses BA=01 with address 0. The precharge drives A10=1.
- R8: The spacing between consecutive commands is at least the following:
  - precharge to next command: `TRP_NOPS`+1 cycles;
  - after each mode load: `TRSC_NOPS`+1 cycles;
  - refresh to refresh: `TRFC_NOPS`+1 cycles.
  Every cycle in between is a NOP.
- R9: `cfg_error` is high whenever the burst length is not 2, 4 or 8, or the CAS latency is not 4 or 5 half-cycles. While it is high at the start, no command other than NOP is issued. The sequence starts once the inputs become legal.
- R10: The configuration is captured when the sequence starts. Changes to the inputs afterwards do not alter the mode load word.
- R11: The command is encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP=0111, precharge=0010, mode load=0000, refresh=0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 4 | Burst length in beats (2, 4 or 8) |
| cfg_interleave | input | 1 | 1 selects interleaved burst order |
| cfg_cas_half | input | 3 | CAS latency in half-cycles (4 or 5) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Address bus |
| init_done | output | 1 | Bring-up complete, memory idle |
| cfg_error | output | 1 | Configuration inputs are illegal |

## Verification
The table-driven runs cover every legal burst length, burst type and CAS latency pairing. They check the packed mode word field by field, so a swapped or shifted field, or a missing DLL reset bit, shows up as a wrong address value. Illegal codes are held for longer than the power-up hold. A design that started anyway, or that emitted a reserved code, would show a command where only NOPs belong.

The bench changes the inputs after the start, to catch a design that encodes from live inputs. It also pulses reset during the refresh phase: a design that resumed mid-sequence, or skipped the long hold, would issue its first command too early. The gap from the last refresh to done is checked to the exact cycle, so an off-by-one in the final wait is caught.

// File: rtl/ddr_init_pkg.sv
// Shared types for the DDR bring-up sequencer.
// Assumes commands are encoded as {cs_n, ras_n, cas_n, we_n}.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } cmd_t;

    typedef enum logic [3:0] {
        S_CHECK,
        S_PWR,
        S_PRE,
        S_TRP,
        S_EMRS,
        S_TEMRS,
        S_MRS,
        S_TMRS,
        S_REF,
        S_TRFC,
        S_FINAL,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/ddr_init_timer.sv
// Reloadable down-counter that times every wait phase of the bring-up.
// Assumes: the caller loads N-1 on the edge that enters an N-cycle wait
// and treats 'expired' as the last cycle of that wait.
module ddr_init_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_q;

    // Purpose: reload on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R8: an unloaded, nonzero count decreases by exactly one per cycle
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_init_modeword.sv
// Validates burst length and CAS latency inputs and packs them into the
// mode register word, with the DLL reset bit set.
// Assumes: burst length is given in beats, CAS latency in half-cycles.
module ddr_init_modeword (
    input  logic [3:0]  burst_len,
    input  logic        interleave,
    input  logic [2:0]  cas_half,
    output logic        cfg_ok,
    output logic [12:0] word
);

    logic [2:0] bl_code;
    logic [2:0] cl_code;
    logic       bl_ok;
    logic       cl_ok;

    // Purpose: map the burst length in beats to its field code.
    always_comb begin
        bl_ok   = 1'b1;
        bl_code = 3'b000;
        case (burst_len)
            4'd2:    bl_code = 3'b001;
            4'd4:    bl_code = 3'b010;
            4'd8:    bl_code = 3'b011;
            default: bl_ok   = 1'b0;
        endcase
    end

    // Purpose: map the CAS latency in half-cycles to its field code.
    always_comb begin
        cl_ok   = 1'b1;
        cl_code = 3'b000;
        case (cas_half)
            3'd4:    cl_code = 3'b010;
            3'd5:    cl_code = 3'b110;
            default: cl_ok   = 1'b0;
        endcase
    end

    assign cfg_ok = bl_ok && cl_ok;
    // A12..A9 zero, A8 DLL reset, A7 zero, A6..A4 latency, A3 type, A2..A0 length
    assign word   = {4'b0000, 1'b1, 1'b0, cl_code, interleave, bl_code};

endmodule

// File: rtl/ddr_init_cmdgen.sv
// Decodes the sequencer state into command pins, bank and address.
// Assumes: each command state lasts one cycle; all other states drive NOP.
module ddr_init_cmdgen
    import ddr_init_pkg::*;
(
    input  seq_state_t  state,
    input  logic [12:0] mr_word,
    output logic [3:0]  cmd,
    output logic [1:0]  ba,
    output logic [12:0] addr
);

    // Purpose: pick command, bank and address for the current state.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = 2'b00;
        addr = '0;
        case (state)
            S_PRE: begin
                cmd      = CMD_PRE;
                addr[10] = 1'b1;
            end
            S_EMRS: begin
                cmd = CMD_MRS;
                ba  = 2'b01;
            end
            S_MRS: begin
                cmd  = CMD_MRS;
                addr = mr_word;
            end
            S_REF:   cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
// DDR SDRAM bring-up sequencer top.
// Assumes: clock and supplies are stable when rst_n is released; the
// configuration inputs are sampled only at the start of the sequence.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int POWERUP_NS    = 200000,
    parameter int TRP_NOPS      = 2,
    parameter int TRSC_NOPS     = 2,
    parameter int TRFC_NOPS     = 10,
    parameter int REFRESH_COUNT = 2,
    parameter int FINAL_NOPS    = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  cfg_burst_len,
    input  logic        cfg_interleave,
    input  logic [2:0]  cfg_cas_half,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [12:0] addr,
    output logic        init_done,
    output logic        cfg_error
);

    localparam int PWR_RAW  = (POWERUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int PWR_CYC  = (PWR_RAW < 1) ? 1 : PWR_RAW;
    localparam int TRP_CYC  = (TRP_NOPS < 1) ? 1 : TRP_NOPS;
    localparam int TRSC_CYC = (TRSC_NOPS < 1) ? 1 : TRSC_NOPS;
    localparam int TRFC_CYC = (TRFC_NOPS < 1) ? 1 : TRFC_NOPS;
    localparam int FIN_CYC  = (FINAL_NOPS < TRFC_CYC) ? TRFC_CYC : FINAL_NOPS;
    localparam int NREF     = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
    localparam int MAX_A    = (PWR_CYC > FIN_CYC) ? PWR_CYC : FIN_CYC;
    localparam int MAX_B    = (TRP_CYC > TRSC_CYC) ? TRP_CYC : TRSC_CYC;
    localparam int MAX_C    = (MAX_B > TRFC_CYC) ? MAX_B : TRFC_CYC;
    localparam int TMR_MAX  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int TW       = $clog2(TMR_MAX + 1);
    localparam int RW       = $clog2(NREF + 1);

    seq_state_t  state_q, state_d;
    logic [RW-1:0] ref_cnt_q;
    logic [12:0] mr_word_q;
    logic [12:0] live_word;
    logic        live_ok;
    logic        tmr_load;
    logic [TW-1:0] tmr_val;
    logic        tmr_exp;
    logic        last_ref;
    logic [3:0]  cmd_w;

    ddr_init_modeword u_modeword (
        .burst_len  (cfg_burst_len),
        .interleave (cfg_interleave),
        .cas_half   (cfg_cas_half),
        .cfg_ok     (live_ok),
        .word       (live_word)
    );

    ddr_init_timer #(.WIDTH(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    ddr_init_cmdgen u_cmdgen (
        .state   (state_q),
        .mr_word (mr_word_q),
        .cmd     (cmd_w),
        .ba      (ba),
        .addr    (addr)
    );

    assign last_ref = (ref_cnt_q == RW'(NREF - 1));

    // Purpose: choose the next phase of the fixed bring-up order.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_CHECK: if (live_ok) state_d = S_PWR;
            S_PWR:   if (tmr_exp) state_d = S_PRE;
            S_PRE:   state_d = S_TRP;
            S_TRP:   if (tmr_exp) state_d = S_EMRS;
            S_EMRS:  state_d = S_TEMRS;
            S_TEMRS: if (tmr_exp) state_d = S_MRS;
            S_MRS:   state_d = S_TMRS;
            S_TMRS:  if (tmr_exp) state_d = S_REF;
            S_REF:   state_d = last_ref ? S_FINAL : S_TRFC;
            S_TRFC:  if (tmr_exp) state_d = S_REF;
            S_FINAL: if (tmr_exp) state_d = S_DONE;
            S_DONE:  state_d = S_DONE;
            default: state_d = S_CHECK;
        endcase
    end

    // Purpose: load the timer with the length of the wait being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_PWR:   tmr_val = TW'(PWR_CYC - 1);
            S_TRP:   tmr_val = TW'(TRP_CYC - 1);
            S_TEMRS: tmr_val = TW'(TRSC_CYC - 1);
            S_TMRS:  tmr_val = TW'(TRSC_CYC - 1);
            S_TRFC:  tmr_val = TW'(TRFC_CYC - 1);
            S_FINAL: tmr_val = TW'(FIN_CYC - 1);
            default: tmr_val = '0;
        endcase
    end

    // Purpose: phase register, refresh counter and configuration capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_CHECK;
            ref_cnt_q <= '0;
            mr_word_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CHECK && live_ok) begin
                mr_word_q <= live_word;
            end
            if (state_q == S_REF) begin
                ref_cnt_q <= ref_cnt_q + 1'b1;
            end
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_w;
    assign init_done = (state_q == S_DONE);
    assign cfg_error = !live_ok;

    // R1: right after reset release the bus is quiet and done is low
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmd_w == CMD_NOP && !init_done));

    // R6: the mode load never carries a reserved or stray field
    p_mode_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_MRS && ba == 2'b00) |->
        (addr[8] && !addr[7] && addr[12:9] == 4'b0000 &&
         (addr[2:0] == 3'b001 || addr[2:0] == 3'b010 || addr[2:0] == 3'b011) &&
         (addr[6:4] == 3'b010 || addr[6:4] == 3'b110)));

    // R7: the extended load enables the DLL with an all-zero word
    p_emrs_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_MRS && ba == 2'b01) |-> (addr == 13'd0));

    // R7: precharge always targets every bank
    p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w == CMD_PRE) |-> addr[10]);

    // R8: no two commands back to back
    p_gap_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w != CMD_NOP) |=> (cmd_w == CMD_NOP));

    // R9: an illegal configuration keeps the sequence parked at its start
    p_hold_on_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_error && state_q == S_CHECK) |=> (state_q == S_CHECK));

    // R10: once started, the captured word never changes
    p_word_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_CHECK && $past(state_q) != S_CHECK) |-> $stable(mr_word_q));

    // R5: done is sticky
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R5: nothing but NOP once done
    p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd_w == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

    localparam int CLK_PS  = 4000;
    localparam int PWR_NS  = 400;
    localparam int PWR_CYC = 100;
    localparam int TRP     = 2;
    localparam int TRSC    = 2;
    localparam int TRFC    = 10;
    localparam int NREF    = 3;
    localparam int FINAL   = 200;
    localparam int NEV     = 3 + NREF;
    localparam int RUN_LIM = PWR_CYC + 600;
    localparam int NVEC    = 10;

    // {burst_len[3:0], interleave, cas_half[2:0], expected word[12:0], error}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd2, 1'b0, 3'd4, 13'h121, 1'b0},
        {4'd4, 1'b1, 3'd5, 13'h16A, 1'b0},
        {4'd8, 1'b0, 3'd5, 13'h163, 1'b0},
        {4'd8, 1'b1, 3'd4, 13'h12B, 1'b0},
        {4'd4, 1'b0, 3'd4, 13'h122, 1'b0},
        {4'd2, 1'b1, 3'd5, 13'h169, 1'b0},
        {4'd3, 1'b0, 3'd4, 13'h000, 1'b1},
        {4'd2, 1'b0, 3'd6, 13'h000, 1'b1},
        {4'd0, 1'b1, 3'd5, 13'h000, 1'b1},
        {4'd8, 1'b0, 3'd3, 13'h000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_burst_len = 4'd2;
    logic        cfg_interleave = 1'b0;
    logic [2:0]  cfg_cas_half = 3'd4;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        init_done, cfg_error;

    int n_chk = 0;
    int n_fail = 0;

    int          cyc = 0;
    int          n_ev = 0;
    int          done_cyc = -1;
    logic [3:0]  ev_cmd  [16];
    int          ev_cyc  [16];
    logic [1:0]  ev_ba   [16];
    logic [12:0] ev_addr [16];

    always #2ns clk = ~clk;

    ddr_init_seq #(
        .CLK_PERIOD_PS (CLK_PS),
        .POWERUP_NS    (PWR_NS),
        .TRP_NOPS      (TRP),
        .TRSC_NOPS     (TRSC),
        .TRFC_NOPS     (TRFC),
        .REFRESH_COUNT (NREF),
        .FINAL_NOPS    (FINAL)
    ) u_ddr_init_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_burst_len  (cfg_burst_len),
        .cfg_interleave (cfg_interleave),
        .cfg_cas_half   (cfg_cas_half),
        .cs_n           (cs_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n),
        .ba             (ba),
        .addr           (addr),
        .init_done      (init_done),
        .cfg_error      (cfg_error)
    );

    // Bus monitor: logs every non-NOP command with its cycle since reset release
    always @(negedge clk) begin
        if (!rst_n) begin
            cyc      = 0;
            n_ev     = 0;
            done_cyc = -1;
        end else begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'b0111 && !cs_n) begin
                if (n_ev < 16) begin
                    ev_cmd[n_ev]  = {cs_n, ras_n, cas_n, we_n};
                    ev_cyc[n_ev]  = cyc;
                    ev_ba[n_ev]   = ba;
                    ev_addr[n_ev] = addr;
                end
                n_ev = n_ev + 1;
            end
            if (init_done && done_cyc < 0) done_cyc = cyc;
            cyc = cyc + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic set_cfg(input logic [3:0] bl, input logic it, input logic [2:0] cl);
        @(posedge clk); #1;
        cfg_burst_len  = bl;
        cfg_interleave = it;
        cfg_cas_half   = cl;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < RUN_LIM && !init_done; i++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Checks a full logged run against the requirements
    task automatic check_run(input logic [12:0] exp_word);
        check(n_ev == NEV, "R3 R4 command count", n_ev, NEV);
        if (n_ev == NEV) begin
            check(ev_cmd[0] == 4'b0010, "R3 R11 first is precharge", ev_cmd[0], 4'b0010);
            check(ev_cmd[1] == 4'b0000 && ev_ba[1] == 2'b01, "R3 R7 extended load", ev_ba[1], 1);
            check(ev_cmd[2] == 4'b0000 && ev_ba[2] == 2'b00, "R3 R7 mode load bank", ev_ba[2], 0);
            for (int k = 3; k < NEV; k++)
                check(ev_cmd[k] == 4'b0001, "R4 R11 refresh", ev_cmd[k], 4'b0001);
            check(ev_cyc[0] >= PWR_CYC, "R2 power-up hold", ev_cyc[0], PWR_CYC);
            check(ev_addr[0][10] == 1'b1, "R7 precharge A10", ev_addr[0][10], 1);
            check(ev_addr[1] == 13'd0, "R7 extended word", ev_addr[1], 0);
            check(ev_addr[2] == exp_word, "R6 mode word", ev_addr[2], exp_word);
            check(ev_cyc[1] - ev_cyc[0] >= TRP + 1, "R8 tRP gap", ev_cyc[1] - ev_cyc[0], TRP + 1);
            check(ev_cyc[2] - ev_cyc[1] >= TRSC + 1, "R8 gap after extended load",
                  ev_cyc[2] - ev_cyc[1], TRSC + 1);
            check(ev_cyc[3] - ev_cyc[2] >= TRSC + 1, "R8 tRSC gap", ev_cyc[3] - ev_cyc[2], TRSC + 1);
            for (int k = 4; k < NEV; k++)
                check(ev_cyc[k] - ev_cyc[k-1] >= TRFC + 1, "R8 tRFC gap",
                      ev_cyc[k] - ev_cyc[k-1], TRFC + 1);
            check(done_cyc - ev_cyc[NEV-1] == FINAL + 1, "R5 final wait",
                  done_cyc - ev_cyc[NEV-1], FINAL + 1);
        end
        check(init_done == 1'b1, "R5 done held", init_done, 1);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 reset NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        check(init_done == 1'b0, "R1 reset done low", init_done, 0);

        // Table walk: legal configs run fully, illegal ones must never start
        for (int v = 0; v < NVEC; v++) begin
            set_cfg(VEC[v][21:18], VEC[v][17], VEC[v][16:14]);
            do_reset();
            if (VEC[v][0]) begin
                repeat (PWR_CYC + 40) @(negedge clk);
                check(cfg_error == 1'b1, "R9 error flag", cfg_error, 1);
                check(n_ev == 0, "R9 no command on error", n_ev, 0);
                check(init_done == 1'b0, "R9 not done on error", init_done, 0);
            end else begin
                check(cfg_error == 1'b0, "R9 no error on legal", cfg_error, 0);
                wait_done();
                check_run(VEC[v][13:1]);
            end
        end

        // R9: fixing an illegal config starts the sequence without reset
        set_cfg(4'd8, 1'b1, 3'd4);
        wait_done();
        check(cfg_error == 1'b0, "R9 error cleared", cfg_error, 0);
        check_run(13'h12B);

        // R10: input change after the start leaves the word unchanged
        set_cfg(4'd2, 1'b0, 3'd4);
        do_reset();
        repeat (10) @(negedge clk);
        set_cfg(4'd8, 1'b1, 3'd5);
        wait_done();
        check_run(13'h121);

        // R1: reset in the refresh phase restarts from the long hold
        set_cfg(4'd4, 1'b1, 3'd5);
        do_reset();
        for (int i = 0; i < RUN_LIM && n_ev < 4; i++) @(negedge clk);
        check(n_ev >= 4, "R1 reached refresh", n_ev, 4);
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 mid reset NOP",
              {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        check(init_done == 1'b0, "R1 mid reset done low", init_done, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        wait_done();
        check_run(13'h16A);

        summary();
        $finish;
    end

endmodule